// File: doc/BRIEF.md
# TPM Register Transaction Master over SPI

This block runs one register access at a time toward a trusted platform module attached over SPI. A request carries a direction, a byte count between 1 and 64 (given as count minus one) and a 24-bit register address. The engine first wakes the device with a short chip-select pulse followed by an idle gap. It then opens the frame with a four-byte header and polls the device for wait states, one byte at a time. Once the device signals ready, it moves the data bytes and closes the frame.

Write data enters and read data leaves through byte-wide valid/ready ports. Every request ends with a one-cycle `done` pulse. The `error` output, valid with that pulse, reports whether the device failed to leave its wait state in time. All timing comes from a microsecond prescaler derived from the clock frequency parameter. The SPI clock half-period is a separate parameter.

Top module: `tpm_spi_master`

## Requirements
- R1: The first header byte carries the direction in bit 7 (1 = read, 0 = write), a constant 1 in bit 6 and the byte count minus one in bits 5:0.
- R2: Header bytes two, three and four carry the 24-bit register address, most significant byte first.
- R3: SPI mode 0. SCK idles low and stays low whenever chip select is high. MOSI changes only while SCK is low (after falling edges), MISO is sampled on rising edges, and each byte goes MSB first.
- R4: After the header, chip select stays low and at least one poll byte is clocked with MOSI held at 0. Polling repeats until a received byte has bit 0 set, whatever its other bits are. The data phase follows immediately.
- R5: If no ready byte arrives within POLL_LIMIT_US microseconds of the end of the header, the engine releases chip select at the end of the current poll byte and finishes the request with `error` = 1.
- R6: On a timed-out read, the read port still delivers the requested number of bytes, all 0x00. On a timed-out write, no write byte is accepted.
- R7: Before each frame, chip select is driven low for WAKE_LO_US microseconds, then high for WAKE_GAP_US microseconds, with no SCK activity.
- R8: Chip select is low in one unbroken stretch from the first header bit until the last data bit, and is high whenever the engine is idle.
- R9: A write takes exactly the requested number of bytes through `wr_valid`/`wr_ready`, only while the frame is open, and sends them in the order accepted.
- R10: A read presents each received byte on `rd_data` with `rd_valid`, holds it until `rd_ready`, and drives MOSI to 0 while clocking read bytes.
- R11: `done` is a single-cycle pulse, once per request. `error` is 0 on a successful request. `req_ready` is high only while idle, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_cnt_m1 | input | 6 | Byte count minus one |
| req_addr | input | 24 | Register address |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Engine takes the write byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | Wait-state timeout flag, valid with done |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |

## Verification
The slave model answers wait bytes as 0xFE. An engine that tests the whole byte instead of bit 0 would therefore stop early or never stop. The model also returns a zero flag during the header, so a design that skips the mandatory poll byte misplaces every data byte. Boundary counts of 1 and 64 bytes expose an off-by-one in the header length field or in the data counter. A 64-byte read with a stalling consumer catches data lost or overwritten under backpressure. Timeouts are forced in both directions: a wrong design would keep chip select low, flag no error, drop the zero fill on reads or swallow write bytes. A clean access afterwards shows that no state leaks across the failure.

// File: rtl/tpm_spi_master.sv
module tpm_spi_master #(
  parameter int CLK_FREQ_HZ   = 200_000_000,
  parameter int SCK_HALF      = 2,
  parameter int WAKE_LO_US    = 1,
  parameter int WAKE_GAP_US   = 100,
  parameter int POLL_LIMIT_US = 100_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_read,
  input  logic [5:0]  req_cnt_m1,
  input  logic [23:0] req_addr,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic        done,
  output logic        error,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int TPU     = (CLK_FREQ_HZ / 1_000_000 > 0) ? CLK_FREQ_HZ / 1_000_000 : 1;
  localparam int PRE_W   = $clog2(TPU + 1);
  localparam int DIV_W   = $clog2(SCK_HALF + 1);
  localparam int T_A     = (WAKE_LO_US > WAKE_GAP_US) ? WAKE_LO_US : WAKE_GAP_US;
  localparam int TMR_MAX = (T_A > POLL_LIMIT_US) ? T_A : POLL_LIMIT_US;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAKE_LO, S_WAKE_GAP, S_HDR, S_POLL, S_DATA, S_ZERO, S_DONE
  } st_t;

  st_t              st;
  logic             is_rd;
  logic [5:0]       cnt_m1;
  logic [23:0]      addr;
  logic [6:0]       idx;
  logic [PRE_W-1:0] pre;
  logic [TMR_W-1:0] tmr;
  logic             sh_busy, sck_r, cs_n_r, rdv_r, done_r, err_r;
  logic [7:0]       sh_tx, sh_rx, rdd_r;
  logic [2:0]       bitn;
  logic [DIV_W-1:0] div;

  logic       us_tick, half_end, fin, more, poll_out;
  logic       rd_launch, wr_launch, lch;
  logic [1:0] hsel;
  logic [7:0] hb, lb;

  assign us_tick   = (pre == PRE_W'(TPU - 1));
  assign half_end  = sh_busy && (div == DIV_W'(SCK_HALF - 1));
  assign fin       = half_end && sck_r && (bitn == 3'd7);
  assign more      = (idx != ({1'b0, cnt_m1} + 7'd1));
  assign poll_out  = (tmr == TMR_W'(POLL_LIMIT_US));
  assign rd_launch = (st == S_DATA) && is_rd && !sh_busy && !rdv_r && more;
  assign wr_ready  = (st == S_DATA) && !is_rd && !sh_busy && more;
  assign wr_launch = wr_ready && wr_valid;
  assign hsel      = (st == S_HDR) ? idx[1:0] + 2'd1 : 2'd0;

  always_comb begin
    case (hsel)
      2'd0:    hb = {is_rd, 1'b1, cnt_m1};
      2'd1:    hb = addr[23:16];
      2'd2:    hb = addr[15:8];
      default: hb = addr[7:0];
    endcase
  end

  always_comb begin
    lch = 1'b0;
    lb  = 8'h00;
    case (st)
      S_WAKE_GAP: begin
        lch = us_tick && (tmr == TMR_W'(WAKE_GAP_US - 1));
        lb  = hb;
      end
      S_HDR: begin
        lch = fin;
        lb  = (idx == 7'd3) ? 8'h00 : hb;
      end
      S_POLL:  lch = fin && !sh_rx[0] && !poll_out;
      S_DATA: begin
        lch = rd_launch || wr_launch;
        lb  = is_rd ? 8'h00 : wr_data;
      end
      default: lch = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_rd   <= 1'b0;
      cnt_m1  <= '0;
      addr    <= '0;
      idx     <= '0;
      pre     <= '0;
      tmr     <= '0;
      sh_busy <= 1'b0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      bitn    <= '0;
      div     <= '0;
      sck_r   <= 1'b0;
      cs_n_r  <= 1'b1;
      rdv_r   <= 1'b0;
      rdd_r   <= '0;
      done_r  <= 1'b0;
      err_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (rdv_r && rd_ready) rdv_r <= 1'b0;
      pre <= us_tick ? '0 : pre + PRE_W'(1);

      if (half_end) begin
        div <= '0;
        if (!sck_r) begin
          sck_r <= 1'b1;
          sh_rx <= {sh_rx[6:0], spi_miso};
        end else begin
          sck_r <= 1'b0;
          if (bitn == 3'd7) sh_busy <= 1'b0;
          else begin
            bitn  <= bitn + 3'd1;
            sh_tx <= {sh_tx[6:0], 1'b0};
          end
        end
      end else if (sh_busy) begin
        div <= div + DIV_W'(1);
      end
      if (lch) begin
        sh_busy <= 1'b1;
        sh_tx   <= lb;
        bitn    <= '0;
        div     <= '0;
      end

      case (st)
        S_IDLE: if (req_valid) begin
          is_rd  <= req_read;
          cnt_m1 <= req_cnt_m1;
          addr   <= req_addr;
          err_r  <= 1'b0;
          cs_n_r <= 1'b0;
          pre    <= '0;
          tmr    <= '0;
          st     <= S_WAKE_LO;
        end
        S_WAKE_LO: if (us_tick) begin
          if (tmr == TMR_W'(WAKE_LO_US - 1)) begin
            tmr    <= '0;
            cs_n_r <= 1'b1;
            st     <= S_WAKE_GAP;
          end else tmr <= tmr + TMR_W'(1);
        end
        S_WAKE_GAP: if (us_tick) begin
          if (tmr == TMR_W'(WAKE_GAP_US - 1)) begin
            cs_n_r <= 1'b0;
            idx    <= '0;
            st     <= S_HDR;
          end else tmr <= tmr + TMR_W'(1);
        end
        S_HDR: if (fin) begin
          if (idx == 7'd3) begin
            idx <= '0;
            tmr <= '0;
            pre <= '0;
            st  <= S_POLL;
          end else idx <= idx + 7'd1;
        end
        S_POLL: begin
          if (us_tick && !poll_out) tmr <= tmr + TMR_W'(1);
          if (fin) begin
            if (sh_rx[0]) st <= S_DATA;
            else if (poll_out) begin
              cs_n_r <= 1'b1;
              err_r  <= 1'b1;
              st     <= is_rd ? S_ZERO : S_DONE;
            end
          end
        end
        S_DATA: if (fin) begin
          idx <= idx + 7'd1;
          if (is_rd) begin
            rdd_r <= sh_rx;
            rdv_r <= 1'b1;
          end
          if (idx == {1'b0, cnt_m1}) begin
            cs_n_r <= 1'b1;
            st     <= S_DONE;
          end
        end
        S_ZERO: if (!rdv_r) begin
          if (more) begin
            rdd_r <= 8'h00;
            rdv_r <= 1'b1;
            idx   <= idx + 7'd1;
          end else st <= S_DONE;
        end
        S_DONE: if (!rdv_r) begin
          done_r <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rd_data   = rdd_r;
  assign rd_valid  = rdv_r;
  assign done      = done_r;
  assign error     = err_r;
  assign spi_sck   = sck_r;
  assign spi_cs_n  = cs_n_r;
  assign spi_mosi  = sh_tx[7];

endmodule

// File: rtl/tpm_spi_master_chk.sv
module tpm_spi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       done,
  input logic       spi_sck,
  input logic       spi_cs_n
);

  AST_SCK_LOW_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R3

  AST_IDLE_CS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n); // R8

  AST_WR_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> !spi_cs_n); // R9

  AST_RD_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

endmodule

bind tpm_spi_master tpm_spi_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .done(done), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n)
);

// File: tb/tpm_spi_master_bench.sv
`timescale 1ns/1ps
module tpm_spi_master_bench;
  localparam int TPU = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [5:0] req_cnt_m1 = '0;
  logic [23:0] req_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic req_ready, wr_ready, rd_valid, done, error, spi_sck, spi_cs_n, spi_mosi;
  logic [7:0] rd_data;
  logic miso_q = 1'b0;

  always #2.5 clk = ~clk;

  tpm_spi_master #(
    .CLK_FREQ_HZ(200_000_000), .SCK_HALF(2), .WAKE_LO_US(1),
    .WAKE_GAP_US(4), .POLL_LIMIT_US(20)
  ) u_tpm_spi_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_cnt_m1(req_cnt_m1), .req_addr(req_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .error(error), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(miso_q)
  );

  int nchk = 0, nfail = 0;

  // slave model
  int s_bit = 0, s_byte = 0, s_nwait = 0;
  logic [7:0] s_sh = '0;
  logic [7:0] mlog [512];
  logic cs_q = 1'b1, sck_q = 1'b0;

  function automatic logic [7:0] pat(int j);
    return 8'((j * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] resp(int k);
    if (k < 4) return 8'h00;
    if (k < 4 + s_nwait) return 8'hFE;
    if (k == 4 + s_nwait) return 8'h01;
    return pat(k - 5 - s_nwait);
  endfunction

  always @(spi_cs_n or spi_sck) begin
    logic [7:0] t;
    if (spi_cs_n !== cs_q && spi_cs_n == 1'b0) begin
      s_bit = 0; s_byte = 0;
      t = resp(0); miso_q = t[7];
    end else if (spi_sck !== sck_q) begin
      if (spi_sck) s_sh = {s_sh[6:0], spi_mosi};
      else begin
        s_bit++;
        if (s_bit == 8) begin
          if (s_byte < 512) mlog[s_byte] = s_sh;
          s_byte++; s_bit = 0;
        end
        t = resp(s_byte); miso_q = t[7 - s_bit];
      end
    end
    cs_q = spi_cs_n; sck_q = spi_sck;
  end

  // results of the last request
  logic [7:0] wbytes [64];
  logic [7:0] rbytes [64];
  int nr, nacc, elapsed, nruns, mviol;
  int runs [16];
  logic got_err, cs_at_done;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input bit rd, input int n, input logic [23:0] a, input int nw, input bit stall);
    int wi, run;
    logic pcs, pm;
    bit pend;
    s_nwait = nw;
    for (int j = 0; j < 64; j++) wbytes[j] = 8'h90 ^ 8'(j * 13);
    nr = 0; nacc = 0; elapsed = 0; nruns = 0; mviol = 0; got_err = 1'b0;
    wi = 0; run = 0; pcs = 1'b1; pm = spi_mosi; pend = 0;
    @(negedge clk);
    req_read = rd; req_cnt_m1 = 6'(n - 1); req_addr = a; req_valid = 1'b1;
    wr_data = wbytes[0]; wr_valid = !rd;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      elapsed++;
      if (spi_cs_n !== pcs) begin
        if (nruns < 16) runs[nruns] = run;
        nruns++; run = 1; pcs = spi_cs_n;
      end else run++;
      if (spi_mosi !== pm && spi_sck && !spi_cs_n) mviol++;
      pm = spi_mosi;
      if (pend) begin
        wi++; pend = 0;
        wr_data = (wi < 64) ? wbytes[wi] : 8'h00;
        wr_valid = (wi < n);
      end
      if (wr_valid && wr_ready) begin pend = 1; nacc++; end
      rd_ready = stall ? (elapsed % 3 == 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        if (nr < 64) rbytes[nr] = rd_data;
        nr++;
      end
      if (done) begin
        got_err = error; cs_at_done = spi_cs_n;
        break;
      end
      if (elapsed > 30000) begin
        chk(0, "R11 request never finished", elapsed, 0);
        break;
      end
    end
    wr_valid = 1'b0; rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic common_ok(input string name);
    chk(got_err == 1'b0, {"R11 error clear ", name}, got_err, 0);
    chk(mviol == 0, {"R3 mosi moved while sck high ", name}, mviol, 0);
    chk(nruns == 4, {"R8 cs transitions ", name}, nruns, 4);
    chk(runs[1] >= TPU - 1 && runs[1] <= TPU + 1, {"R7 wake low length ", name}, runs[1], TPU);
    chk(runs[2] >= 4*TPU - 1 && runs[2] <= 4*TPU + 1, {"R7 wake gap length ", name}, runs[2], 4*TPU);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R11 req_ready after reset", req_ready, 1);
    chk(spi_cs_n == 1'b1, "R8 cs high after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R3 sck low after reset", spi_sck, 0);
    chk(done == 1'b0 && rd_valid == 1'b0, "R11 done/rd_valid low after reset", {done, rd_valid}, 0);
  endtask

  task automatic t_read_basic;
    bit ok;
    run_req(1, 4, 24'hD40018, 3, 0);
    chk(mlog[0] == 8'hC3, "R1 read header byte", mlog[0], 8'hC3);
    chk({mlog[1], mlog[2], mlog[3]} == 24'hD40018, "R2 address bytes", {mlog[1], mlog[2], mlog[3]}, 24'hD40018);
    chk(s_byte == 4 + 3 + 1 + 4, "R4 poll count then data", s_byte, 12);
    ok = 1;
    for (int k = 4; k < 12; k++) if (mlog[k] != 8'h00) ok = 0;
    chk(ok, "R10 mosi zero during poll and read bytes", ok, 1);
    chk(nr == 4, "R10 read byte count", nr, 4);
    for (int j = 0; j < 4; j++) chk(rbytes[j] == pat(j), "R10 read data", rbytes[j], pat(j));
    common_ok("read4");
  endtask

  task automatic t_write_basic;
    run_req(0, 3, 24'h000F90, 0, 0);
    chk(mlog[0] == 8'h42, "R1 write header byte", mlog[0], 8'h42);
    chk({mlog[1], mlog[2], mlog[3]} == 24'h000F90, "R2 address bytes", {mlog[1], mlog[2], mlog[3]}, 24'h000F90);
    chk(s_byte == 4 + 1 + 3, "R4 single poll then data", s_byte, 8);
    chk(nacc == 3, "R9 write bytes accepted", nacc, 3);
    for (int j = 0; j < 3; j++) chk(mlog[5 + j] == wbytes[j], "R9 write data on mosi", mlog[5 + j], wbytes[j]);
    common_ok("write3");
  endtask

  task automatic t_read_max;
    bit ok;
    run_req(1, 64, 24'h123456, 1, 1);
    chk(mlog[0] == 8'hFF, "R1 header for 64 byte read", mlog[0], 8'hFF);
    chk(nr == 64, "R10 read count under backpressure", nr, 64);
    ok = 1;
    for (int j = 0; j < 64; j++) if (rbytes[j] != pat(j)) ok = 0;
    chk(ok, "R10 read data under backpressure", ok, 1);
    chk(s_byte == 4 + 2 + 64, "R4 bytes clocked", s_byte, 70);
    common_ok("read64");
  endtask

  task automatic t_write_one;
    bit ok;
    run_req(0, 1, 24'hABCDEF, 5, 0);
    chk(mlog[0] == 8'h40, "R1 header for 1 byte write", mlog[0], 8'h40);
    ok = 1;
    for (int k = 4; k < 10; k++) if (mlog[k] != 8'h00) ok = 0;
    chk(ok, "R4 mosi zero while polling", ok, 1);
    chk(mlog[10] == wbytes[0], "R9 single write byte", mlog[10], wbytes[0]);
    chk(nacc == 1 && s_byte == 11, "R9 exactly one byte", nacc, 1);
    common_ok("write1");
  endtask

  task automatic t_timeout_read;
    bit ok;
    run_req(1, 2, 24'h000024, 1_000_000, 0);
    chk(got_err == 1'b1, "R5 timeout flagged", got_err, 1);
    chk(cs_at_done == 1'b1, "R5 cs released", cs_at_done, 1);
    chk(elapsed >= 5100 && elapsed <= 5300, "R5 timeout duration", elapsed, 5150);
    chk(nr == 2, "R6 zero fill count", nr, 2);
    chk(rbytes[0] == 8'h00 && rbytes[1] == 8'h00, "R6 zero fill data", {rbytes[0], rbytes[1]}, 0);
    ok = 1;
    for (int k = 4; k < s_byte && k < 512; k++) if (mlog[k] != 8'h00) ok = 0;
    chk(ok && s_byte > 4, "R4 polling kept going with mosi zero", s_byte, 5);
    chk(nruns == 4, "R8 cs transitions on timeout", nruns, 4);
  endtask

  task automatic t_timeout_write;
    run_req(0, 2, 24'h000018, 1_000_000, 0);
    chk(got_err == 1'b1, "R5 write timeout flagged", got_err, 1);
    chk(nacc == 0, "R6 no write byte taken", nacc, 0);
    chk(cs_at_done == 1'b1, "R5 cs released on write", cs_at_done, 1);
  endtask

  task automatic t_recover;
    run_req(1, 2, 24'h0F0F0F, 0, 0);
    chk(nr == 2 && rbytes[0] == pat(0) && rbytes[1] == pat(1), "R11 clean access after timeout", {rbytes[0], rbytes[1]}, {pat(0), pat(1)});
    common_ok("recover");
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R11 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_write_basic();
    t_read_max();
    t_write_one();
    t_timeout_read();
    t_timeout_write();
    t_recover();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule